// File: doc/BRIEF.md
# Real-Time Clock Event Flag and Interrupt Unit

This unit sits beside a real-time clock counter and turns the counter's single-cycle event pulses into sticky status flags. The sources are a second tick, minute, hour, midnight, noon, week, month and year changes, an alarm match and an update acknowledge. One programmable source drives the time-event flag and another drives the calendar-event flag. The other flags are tied to fixed sources. Every flag stays set until software clears it.

Software reaches the unit through a small register port with a write strobe, an address and write data. Read data is a combinational view of the addressed register. A control register picks the two event sources. A clear-command register clears flags by writing ones. Two more registers set and clear interrupt mask bits, one by ones written and one by ones written. A single interrupt line is the registered OR of the flags that are unmasked.

Top module: `rtc_evt_irq`

## Requirements
- R1: Control bits [1:0] select the time-event source: 0 minute change, 1 hour change, 2 midnight, 3 noon. The unselected time sources do not set the time-event flag.
- R2: Control bits [3:2] select the calendar-event source: 0 week change, 1 month change, 2 year change. Value 3 selects nothing, so no pulse sets the calendar-event flag.
- R3: The status register (address 1) holds the flags at these bits: 0 update acknowledge, 1 alarm, 2 second event, 3 time event, 4 calendar event. A flag reads as set in the cycle after its source pulse.
- R4: A set flag stays set until a clear command names it.
- R5: A write to the clear-command register (address 2) clears each flag whose bit in the write data is 1. Bits written as 0 leave their flags unchanged.
- R6: If a source pulse and a clear command hit the same flag in the same cycle, the flag ends set.
- R7: A write to the mask-set register (address 3) sets the mask bits written as 1. A write to the mask-clear register (address 4) clears the mask bits written as 1. The mask reads back at address 5 with the flag bit layout.
- R8: The interrupt output is registered. In each cycle it equals the OR, over all bits, of flag AND mask as they stood one cycle earlier.
- R9: Reset is synchronous and active high. It clears all flags, all mask bits, both select fields and the interrupt output.
- R10: The control register (address 0) is written and read with the time select at bits [1:0] and the calendar select at bits [3:2]. A new selection takes effect for pulses in the cycles after the write.
- R11: Addresses 2, 3, 4 and every address above 5 read as zero. Writes to addresses above 5 change nothing. Data bits above bit 4 (above bit 3 for the control register) are ignored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_sec | input | 1 | Second tick pulse |
| ev_minute | input | 1 | Minute change pulse |
| ev_hour | input | 1 | Hour change pulse |
| ev_midnight | input | 1 | Midnight pulse |
| ev_noon | input | 1 | Noon pulse |
| ev_week | input | 1 | Week change pulse |
| ev_month | input | 1 | Month change pulse |
| ev_year | input | 1 | Year change pulse |
| ev_alarm | input | 1 | Alarm match pulse |
| ev_upd_ack | input | 1 | Update acknowledge pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with DATA_W=16 and ADDR_W=4, which is wider than the defaults. With these values, writes of all ones exercise data bits that the unit must ignore. They also allow writes and reads at ten unmapped addresses (6 to 15), so the bench can show that those writes change nothing and those reads return zero. Random traffic runs against every select value, including the reserved calendar code. It includes clears that collide with pulses and mask updates, and the interrupt line is compared in every cycle.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

    localparam int NUM_FLAGS = 5;

    localparam int FLG_UPD = 0;
    localparam int FLG_ALM = 1;
    localparam int FLG_SEC = 2;
    localparam int FLG_TIM = 3;
    localparam int FLG_CAL = 4;

    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_CLR  = 2;
    localparam int REG_MSET = 3;
    localparam int REG_MCLR = 4;
    localparam int REG_MASK = 5;

    localparam int SEL_W  = 2;
    localparam int CTRL_W = 2 * SEL_W;

    typedef enum logic [SEL_W-1:0] {
        TSEL_MINUTE   = 2'd0,
        TSEL_HOUR     = 2'd1,
        TSEL_MIDNIGHT = 2'd2,
        TSEL_NOON     = 2'd3
    } tsel_e;

    typedef enum logic [SEL_W-1:0] {
        CSEL_WEEK  = 2'd0,
        CSEL_MONTH = 2'd1,
        CSEL_YEAR  = 2'd2,
        CSEL_NONE  = 2'd3
    } csel_e;

    typedef struct packed {
        logic sec;
        logic minute;
        logic hour;
        logic midnight;
        logic noon;
        logic week;
        logic month;
        logic year;
        logic alarm;
        logic upd_ack;
    } evt_in_t;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t clr;
        flag_vec_t mset;
        flag_vec_t mclr;
    } wr_cmd_t;

    function automatic logic pick_time(tsel_e sel, evt_in_t e);
        logic r;
        case (sel)
            TSEL_MINUTE:   r = e.minute;
            TSEL_HOUR:     r = e.hour;
            TSEL_MIDNIGHT: r = e.midnight;
            default:       r = e.noon;
        endcase
        return r;
    endfunction

    function automatic logic pick_cal(csel_e sel, evt_in_t e);
        logic r;
        case (sel)
            CSEL_WEEK:  r = e.week;
            CSEL_MONTH: r = e.month;
            CSEL_YEAR:  r = e.year;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_evt_select.sv
module rtc_evt_select
    import rtc_evt_pkg::*;
(
    input  evt_in_t   evt,
    input  tsel_e     tsel,
    input  csel_e     csel,
    output flag_vec_t set_vec
);

    always_comb begin
        set_vec          = '0;
        set_vec[FLG_UPD] = evt.upd_ack;
        set_vec[FLG_ALM] = evt.alarm;
        set_vec[FLG_SEC] = evt.sec;
        set_vec[FLG_TIM] = pick_time(tsel, evt);
        set_vec[FLG_CAL] = pick_cal(csel, evt);
    end

endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags
    import rtc_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_vec,
    output flag_vec_t status
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else if (set_vec[i]) begin
                q <= 1'b1;
            end else if (clr_vec[i]) begin
                q <= 1'b0;
            end
        end
        assign status[i] = q;
    end

endmodule

// File: rtl/rtc_evt_mask.sv
module rtc_evt_mask
    import rtc_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t mset,
    input  flag_vec_t mclr,
    output flag_vec_t mask
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_mbit
        logic q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 1'b0;
            end else if (mset[i]) begin
                q <= 1'b1;
            end else if (mclr[i]) begin
                q <= 1'b0;
            end
        end
        assign mask[i] = q;
    end

endmodule

// File: rtl/rtc_evt_regport.sv
module rtc_evt_regport
    import rtc_evt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  flag_vec_t         status,
    input  flag_vec_t         mask,
    output tsel_e             tsel_q,
    output csel_e             csel_q,
    output wr_cmd_t           cmd,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(REG_CLR);
    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(REG_MSET);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(REG_MCLR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);

    flag_vec_t wflags;
    logic      unused_wdata_hi;

    assign wflags          = wdata[NUM_FLAGS-1:0];
    assign unused_wdata_hi = ^wdata;

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            if (addr == A_CLR)  cmd.clr  = wflags;
            if (addr == A_MSET) cmd.mset = wflags;
            if (addr == A_MCLR) cmd.mclr = wflags;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tsel_q <= TSEL_MINUTE;
            csel_q <= CSEL_WEEK;
        end else if (wr_en && addr == A_CTRL) begin
            tsel_q <= tsel_e'(wdata[SEL_W-1:0]);
            csel_q <= csel_e'(wdata[CTRL_W-1:SEL_W]);
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[CTRL_W-1:0]    = {csel_q, tsel_q};
            A_STAT:  rdata[NUM_FLAGS-1:0] = status;
            A_MASK:  rdata[NUM_FLAGS-1:0] = mask;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
    import rtc_evt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_sec,
    input  logic              ev_minute,
    input  logic              ev_hour,
    input  logic              ev_midnight,
    input  logic              ev_noon,
    input  logic              ev_week,
    input  logic              ev_month,
    input  logic              ev_year,
    input  logic              ev_alarm,
    input  logic              ev_upd_ack,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    evt_in_t   evt;
    flag_vec_t set_vec;
    flag_vec_t status_q;
    flag_vec_t mask_q;
    tsel_e     tsel_q;
    csel_e     csel_q;
    wr_cmd_t   cmd;
    logic      irq_q;

    assign evt = '{sec: ev_sec, minute: ev_minute, hour: ev_hour,
                   midnight: ev_midnight, noon: ev_noon, week: ev_week,
                   month: ev_month, year: ev_year, alarm: ev_alarm,
                   upd_ack: ev_upd_ack};

    rtc_evt_regport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .status (status_q),
        .mask   (mask_q),
        .tsel_q (tsel_q),
        .csel_q (csel_q),
        .cmd    (cmd),
        .rdata  (rdata)
    );

    rtc_evt_select u_sel (
        .evt     (evt),
        .tsel    (tsel_q),
        .csel    (csel_q),
        .set_vec (set_vec)
    );

    rtc_evt_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (cmd.clr),
        .status  (status_q)
    );

    rtc_evt_mask u_mask (
        .clk  (clk),
        .rst  (rst),
        .mset (cmd.mset),
        .mclr (cmd.mclr),
        .mask (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_q & mask_q);
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/rtc_evt_irq_chk.sv
module rtc_evt_irq_chk
    import rtc_evt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              ev_alarm,
    input flag_vec_t         status_q,
    input flag_vec_t         mask_q,
    input csel_e             csel_q,
    input logic              irq
);

    flag_vec_t clr_v;
    flag_vec_t mset_v;
    flag_vec_t mclr_v;
    logic      unused_wd;

    assign unused_wd = ^wdata;
    assign clr_v  = (wr_en && addr == ADDR_W'(REG_CLR))  ? wdata[NUM_FLAGS-1:0] : '0;
    assign mset_v = (wr_en && addr == ADDR_W'(REG_MSET)) ? wdata[NUM_FLAGS-1:0] : '0;
    assign mclr_v = (wr_en && addr == ADDR_W'(REG_MCLR)) ? wdata[NUM_FLAGS-1:0] : '0;

    p_reserved_cal_r2: assert property (@(posedge clk) disable iff (rst)
        (csel_q == CSEL_NONE && !status_q[FLG_CAL]) |=> !status_q[FLG_CAL]);

    p_alarm_sets_r3: assert property (@(posedge clk) disable iff (rst)
        ev_alarm |=> status_q[FLG_ALM]);

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(status_q & ~clr_v)) == $past(status_q & ~clr_v)));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_v[FLG_ALM] && !ev_alarm) |=> !status_q[FLG_ALM]);

    p_collide_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_v[FLG_ALM] && ev_alarm) |=> status_q[FLG_ALM]);

    p_mask_set_r7: assert property (@(posedge clk) disable iff (rst)
        (mset_v != '0) |=> ((mask_q & $past(mset_v)) == $past(mset_v)));

    p_mask_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (mclr_v != '0) |=> ((mask_q & $past(mclr_v)) == '0));

    p_irq_latency_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(status_q & mask_q))));

    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (status_q == '0 && mask_q == '0 && !irq));

endmodule

bind rtc_evt_irq rtc_evt_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_rtc_evt_irq.sv
module test_rtc_evt_irq;

    localparam int DW = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [9:0]    ev = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    // ev bits: 0 upd_ack, 1 alarm, 2 sec, 3 minute, 4 hour, 5 midnight,
    // 6 noon, 7 week, 8 month, 9 year
    always #2 clk = ~clk;

    rtc_evt_irq #(.DATA_W(DW), .ADDR_W(AW)) i_rtc_evt_irq (
        .clk(clk), .rst(rst),
        .ev_sec(ev[2]), .ev_minute(ev[3]), .ev_hour(ev[4]),
        .ev_midnight(ev[5]), .ev_noon(ev[6]), .ev_week(ev[7]),
        .ev_month(ev[8]), .ev_year(ev[9]), .ev_alarm(ev[1]),
        .ev_upd_ack(ev[0]),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    int errs = 0;
    int checks = 0;

    logic [4:0] m_st = '0;
    logic [4:0] m_mk = '0;
    logic [1:0] m_ts = '0;
    logic [1:0] m_cs = '0;
    logic       m_irq = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] set_of(logic [9:0] e, logic [1:0] ts, logic [1:0] cs);
        logic [4:0] s;
        s[0] = e[0];
        s[1] = e[1];
        s[2] = e[2];
        s[3] = e[3 + ts];
        s[4] = (cs == 2'd3) ? 1'b0 : e[7 + cs];
        return s;
    endfunction

    function automatic logic [DW-1:0] rd_exp(logic [AW-1:0] a);
        case (a)
            0: return DW'({m_cs, m_ts});
            1: return DW'(m_st);
            5: return DW'(m_mk);
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        case (a)
            0: return "R10 control readback";
            1: return "R3 status readback";
            5: return "R7 mask readback";
            default: return "R11 zero readback";
        endcase
    endfunction

    task automatic step(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [9:0] e, input bit do_rd, input string tag);
        logic [4:0] clr;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; ev = e;
        #1;
        if (do_rd) chk(tag, 32'(rdata), 32'(rd_exp(a)));
        @(posedge clk);
        m_irq = |(m_st & m_mk);
        clr = (w && a == 2) ? d[4:0] : 5'd0;
        m_st = (m_st & ~clr) | set_of(e, m_ts, m_cs);
        if (w && a == 3) m_mk = m_mk | d[4:0];
        if (w && a == 4) m_mk = m_mk & ~d[4:0];
        if (w && a == 0) {m_cs, m_ts} = d[3:0];
        #1;
        chk("R8 irq", 32'(irq), 32'(m_irq));
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1'b0, a, '0, '0, 1'b1, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(1'b1, a, d, '0, 1'b0, "");
    endtask

    task automatic pulse(input logic [9:0] e);
        step(1'b0, 4'd1, '0, e, 1'b0, "");
    endtask

    initial begin
        #(4 * 200000);
        errs++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 irq after reset", 32'(irq), 0);
        rd(0, "R9 selects after reset");
        rd(1, "R9 status after reset");
        rd(5, "R9 mask after reset");

        // R3 fixed sources at their bit positions
        pulse(10'b1);   rd(1, "R3 upd ack bit0");
        pulse(10'b10);  rd(1, "R3 alarm bit1");
        pulse(10'b100); rd(1, "R3 second bit2");
        wr(2, 16'hFFFF); rd(1, "R5 clear all");

        // R1 time select
        for (int s = 0; s < 4; s++) begin
            wr(0, 16'(s));
            rd(0, "R10 time select write");
            pulse(10'(4'b1111 & ~(4'b1 << s)) << 3);
            rd(1, "R1 unselected time source");
            pulse(10'(1 << (3 + s)));
            rd(1, "R1 selected time source");
            wr(2, 16'h8);
        end

        // R2 calendar select, including reserved 3
        for (int s = 0; s < 4; s++) begin
            wr(0, 16'(s << 2));
            rd(0, "R10 cal select write");
            pulse(10'b1110000000);
            rd(1, "R2 calendar source all pulses");
            wr(2, 16'h10);
            if (s < 3) begin
                pulse(10'(1 << (7 + s)));
                rd(1, "R2 selected calendar source");
                wr(2, 16'h10);
            end
        end
        wr(0, 16'h0);

        // R4 sticky, R5 zero-write, R6 collision
        pulse(10'b111);
        repeat (5) pulse('0);
        rd(1, "R4 flags held");
        wr(2, 16'h0);        rd(1, "R5 zero write no effect");
        wr(2, 16'h2);        rd(1, "R5 single clear");
        step(1'b1, 2, 16'h1F, 10'b101, 1'b0, "");
        rd(1, "R6 pulse beats clear");

        // R7 mask and R8 irq
        wr(3, 16'hFFE1); rd(5, "R7 mask set");
        wr(4, 16'h0001); rd(5, "R7 mask clear");
        wr(3, 16'h0004); rd(5, "R7 mask set sec");
        wr(2, 16'h1F);   rd(1, "R5 clear all");
        pulse(10'b100);
        #1 chk("R8 irq not yet set", 32'(irq), 0);
        pulse('0);
        chk("R8 irq set one cycle after flag", 32'(irq), 1);

        // R11 unmapped addresses
        for (int a = 6; a < 16; a++) begin
            wr(AW'(a), 16'hFFFF);
            rd(AW'(a), "R11 unmapped read zero");
        end
        rd(0, "R11 control unchanged");
        rd(1, "R11 status unchanged");
        rd(5, "R11 mask unchanged");
        wr(0, 16'hFFF6); rd(0, "R11 control high bits dropped");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic          w;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [9:0]    e;
            w = ($urandom % 3) == 0;
            a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 6);
            d = DW'($urandom);
            for (int b = 0; b < 10; b++) e[b] = ($urandom % 5) == 0;
            step(w, a, d, e, ($urandom % 2) == 1, tag_of(a));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule